// File: doc/BRIEF.md
# Pseudo-Ternary Line Codec with Framing Violations

This block converts a serial bit stream into a three-level pseudo-ternary line code for a basic-rate subscriber bus, and converts such a code back into bits. The line carries 192 kbit/s. Framing and maintenance use 48 kbit/s of that, and the B1, B2 and D channels share the remaining 144 kbit/s. A single bit-enable strobe, one pulse per symbol period, advances both directions. In this code a ONE is silence on the line. Each ZERO is a pulse whose polarity is the opposite of the last pulse sent.

Framing relies on a deliberate code violation: a ZERO pulse that repeats the polarity of the last pulse. The transmitter produces one when its violation request is raised together with a ZERO bit. The receiver compares every pulse with the most recent pulse it saw, so any number of ONE symbols may lie between the two. It flags the violation so that a frame aligner further on can lock to it. On a shared bus a ZERO from any station wins over a ONE, so the receiver decodes ZERO whenever either pulse line is active. It reports a separate collision flag when both lines are active in the same sample.

Top module: `ptl_codec`

## Requirements
- R1: A ONE bit (tx_bit=1) sampled on a bit-enable drives tx_pos=0 and tx_neg=0 for that symbol; tx_pos and tx_neg are never high together.
- R2: A ZERO bit (tx_bit=0) without a violation request drives one pulse whose polarity is opposite to the last pulse sent; the first ZERO after reset is positive (tx_pos=1).
- R3: A ZERO bit with tx_viol=1 repeats the polarity of the last pulse sent, and that pulse becomes the reference for the next ZERO.
- R4: tx_viol has no effect on a ONE bit: no pulse is sent and the polarity reference is unchanged.
- R5: tx_pos and tx_neg change only in the cycle after a bit-enable, and hold their value otherwise.
- R6: On a bit-enable the receiver registers rx_bit=0 if rx_pos or rx_neg is high and rx_bit=1 if both are low; the outputs appear one clock after the enable and hold until the next enable.
- R7: rx_viol is raised for one symbol when a single received pulse has the same polarity as the last single pulse received, with or without no-pulse symbols in between; the flagged pulse becomes the new reference.
- R8: After reset, rx_viol stays low until a first single pulse has set the receive polarity reference.
- R9: When rx_pos and rx_neg are both high on a bit-enable, rx_bit=0, rx_coll=1 and rx_viol=0, and the receive polarity reference is left unchanged.
- R10: While reset is held, tx_pos=0, tx_neg=0, rx_bit=1, rx_viol=0 and rx_coll=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Symbol strobe, one cycle per line symbol |
| tx_bit | input | 1 | Bit to transmit |
| tx_viol | input | 1 | Request to send a same-polarity pulse |
| tx_pos | output | 1 | Positive pulse drive |
| tx_neg | output | 1 | Negative pulse drive |
| rx_pos | input | 1 | Sampled positive pulse indication |
| rx_neg | input | 1 | Sampled negative pulse indication |
| rx_bit | output | 1 | Decoded bit |
| rx_viol | output | 1 | Received code violation flag |
| rx_coll | output | 1 | Both pulse inputs active in one sample |

## Verification
The encoder is driven with runs of ZEROs, which show whether alternation is kept. ZEROs are then mixed with long stretches of ONEs, which show that the reference is the last pulse and not the last symbol. Violation requests are placed both on ZEROs and on ONEs, which separates a real violation from a request that must be ignored. Its line output is looped back into the decoder, and directed receive patterns follow: a pulse right after reset, adjacent and ONE-separated same-polarity pairs, and samples with both lines high. These patterns keep violation detection, the unknown start state and collision handling apart. Gaps of varying length between enables, and back-to-back enables, test that every output changes only on the strobe.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    typedef enum logic [1:0] {
        POL_UNK = 2'b00,
        POL_POS = 2'b01,
        POL_NEG = 2'b10
    } pol_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } sym_t;

    localparam pol_t TX_POL_RESET = POL_NEG;
    localparam pol_t RX_POL_RESET = POL_UNK;
    localparam sym_t SYM_IDLE     = '{pos: 1'b0, neg: 1'b0};

    function automatic pol_t pol_flip(input pol_t p);
        return (p == POL_POS) ? POL_NEG : POL_POS;
    endfunction

    function automatic sym_t pol_to_sym(input pol_t p);
        sym_t s;
        s.pos = (p == POL_POS);
        s.neg = (p == POL_NEG);
        return s;
    endfunction

endpackage

// File: rtl/ptl_encoder.sv
module ptl_encoder
    import ptl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_in,
    input  logic viol_req,
    output sym_t line_out
);

    pol_t last_q;
    pol_t pulse_pol;
    logic send_pulse;

    always_comb begin
        send_pulse = !bit_in;
        pulse_pol  = viol_req ? last_q : pol_flip(last_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= TX_POL_RESET;
            line_out <= SYM_IDLE;
        end else if (bit_en) begin
            if (send_pulse) begin
                line_out <= pol_to_sym(pulse_pol);
                last_q   <= pulse_pol;
            end else begin
                line_out <= SYM_IDLE;
            end
        end
    end

endmodule

// File: rtl/ptl_decoder.sv
module ptl_decoder
    import ptl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  sym_t line_in,
    output logic bit_out,
    output logic viol_out,
    output logic coll_out
);

    pol_t ref_q;
    pol_t seen_pol;
    logic single;
    logic both;

    always_comb begin
        both     = line_in.pos && line_in.neg;
        single   = line_in.pos ^ line_in.neg;
        seen_pol = line_in.pos ? POL_POS : POL_NEG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= RX_POL_RESET;
            bit_out  <= 1'b1;
            viol_out <= 1'b0;
            coll_out <= 1'b0;
        end else if (bit_en) begin
            bit_out  <= !(line_in.pos || line_in.neg);
            coll_out <= both;
            viol_out <= single && (ref_q != POL_UNK) && (ref_q == seen_pol);
            if (single) begin
                ref_q <= seen_pol;
            end
        end
    end

endmodule

// File: rtl/ptl_codec.sv
module ptl_codec
    import ptl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_bit,
    input  logic tx_viol,
    output logic tx_pos,
    output logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rx_bit,
    output logic rx_viol,
    output logic rx_coll
);

    sym_t tx_sym;
    sym_t rx_sym;

    assign rx_sym.pos = rx_pos;
    assign rx_sym.neg = rx_neg;

    ptl_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (tx_bit),
        .viol_req (tx_viol),
        .line_out (tx_sym)
    );

    ptl_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .line_in  (rx_sym),
        .bit_out  (rx_bit),
        .viol_out (rx_viol),
        .coll_out (rx_coll)
    );

    assign tx_pos = tx_sym.pos;
    assign tx_neg = tx_sym.neg;

endmodule

// File: rtl/ptl_codec_chk.sv
module ptl_codec_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic tx_bit,
    input logic tx_viol,
    input logic tx_pos,
    input logic tx_neg,
    input logic rx_pos,
    input logic rx_neg,
    input logic rx_bit,
    input logic rx_viol,
    input logic rx_coll
);

    a_r1_one_is_silent: assert property (@(posedge clk) disable iff (rst)
        (bit_en && tx_bit) |=> (!tx_pos && !tx_neg));

    a_r1_single_level: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_pos, tx_neg}));

    a_r2_zero_pulses: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !tx_bit) |=> (tx_pos || tx_neg));

    a_r5_tx_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(tx_pos) && $stable(tx_neg)));

    a_r6_rx_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(rx_bit) && $stable(rx_viol) && $stable(rx_coll)));

    a_r6_pulse_is_zero: assert property (@(posedge clk) disable iff (rst)
        (bit_en && (rx_pos ^ rx_neg)) |=> (!rx_bit && !rx_coll));

    a_r6_silence_is_one: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !rx_pos && !rx_neg) |=> (rx_bit && !rx_viol && !rx_coll));

    a_r9_collision: assert property (@(posedge clk) disable iff (rst)
        (bit_en && rx_pos && rx_neg) |=> (rx_coll && !rx_bit && !rx_viol));

endmodule

bind ptl_codec ptl_codec_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .tx_bit  (tx_bit),
    .tx_viol (tx_viol),
    .tx_pos  (tx_pos),
    .tx_neg  (tx_neg),
    .rx_pos  (rx_pos),
    .rx_neg  (rx_neg),
    .rx_bit  (rx_bit),
    .rx_viol (rx_viol),
    .rx_coll (rx_coll)
);

// File: tb/sim_ptl_codec.sv
`timescale 1ns/1ps
module sim_ptl_codec;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic tx_bit = 1'b1;
    logic tx_viol = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic tx_pos, tx_neg, rx_bit, rx_viol, rx_coll;

    always #2 clk = ~clk;

    ptl_codec u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .tx_bit(tx_bit), .tx_viol(tx_viol),
        .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rx_pos(rx_pos), .rx_neg(rx_neg),
        .rx_bit(rx_bit), .rx_viol(rx_viol), .rx_coll(rx_coll)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit loopback = 1'b0;

    // Behavioural reference: polarity as +1 / -1, 0 = unknown
    int m_tx_last = -1;
    int m_rx_ref  = 0;
    logic e_tx_pos = 0, e_tx_neg = 0, e_rx_bit = 1, e_rx_viol = 0, e_rx_coll = 0;
    string tx_tag = "R10";
    string rx_tag = "R10";

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_tx_last <= -1; m_rx_ref <= 0;
            e_tx_pos <= 0; e_tx_neg <= 0;
            e_rx_bit <= 1; e_rx_viol <= 0; e_rx_coll <= 0;
            tx_tag <= "R10"; rx_tag <= "R10";
        end else if (!bit_en) begin
            tx_tag <= "R5"; rx_tag <= "R6";
        end else begin
            if (tx_bit) begin
                e_tx_pos <= 0; e_tx_neg <= 0;
                tx_tag <= tx_viol ? "R4" : "R1";
            end else begin
                int p;
                p = tx_viol ? m_tx_last : -m_tx_last;
                e_tx_pos <= (p == 1); e_tx_neg <= (p == -1);
                m_tx_last <= p;
                tx_tag <= tx_viol ? "R3" : "R2";
            end
            e_rx_bit  <= !(rx_pos || rx_neg);
            e_rx_coll <= rx_pos && rx_neg;
            if (rx_pos && rx_neg) begin
                e_rx_viol <= 0; rx_tag <= "R9";
            end else if (rx_pos || rx_neg) begin
                int q;
                q = rx_pos ? 1 : -1;
                e_rx_viol <= (m_rx_ref == q);
                rx_tag <= (m_rx_ref == 0) ? "R8" : "R7";
                m_rx_ref <= q;
            end else begin
                e_rx_viol <= 0; rx_tag <= "R6";
            end
        end
    end

    task automatic cmp(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cmp(tx_tag, "tx_pos", tx_pos, e_tx_pos);
        cmp(tx_tag, "tx_neg", tx_neg, e_tx_neg);
        cmp(rx_tag, "rx_bit", rx_bit, e_rx_bit);
        cmp(rx_tag, "rx_viol", rx_viol, e_rx_viol);
        cmp(rx_tag, "rx_coll", rx_coll, e_rx_coll);
    end

    // One symbol: drive at negedge, enable for one cycle, then idle gap cycles
    task automatic sym(input logic b, input logic v, input logic rp, input logic rn, input int gap);
        @(negedge clk);
        tx_bit = b; tx_viol = v;
        if (loopback) begin rx_pos = tx_pos; rx_neg = tx_neg; end
        else begin rx_pos = rp; rx_neg = rn; end
        bit_en = 1'b1;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8: pulses right after reset; first ZERO positive (R2)
        sym(0, 0, 1, 0, 3);
        sym(0, 0, 1, 0, 2);     // R7 adjacent positive repeat
        sym(0, 0, 0, 1, 4);
        sym(1, 0, 0, 0, 1);
        sym(1, 1, 0, 0, 2);     // R4 request on ONE
        sym(0, 0, 0, 1, 3);     // R7 separated by ONEs
        sym(0, 1, 1, 1, 2);     // R3 violation, R9 collision
        sym(0, 0, 1, 0, 1);
        sym(0, 0, 0, 0, 5);
        sym(1, 0, 1, 0, 3);     // R7 positive after ONE
        // R6: back-to-back enables
        sym(0, 0, 0, 1, 0);
        sym(0, 0, 1, 1, 0);
        sym(0, 0, 0, 1, 1);     // R9 ref unchanged -> violation
        // loopback phase
        loopback = 1'b1;
        for (int k = 0; k < 300; k++) begin
            sym(((k * 7) % 5) < 2, (k % 11) == 3, 0, 0, (k % 4));
        end
        loopback = 1'b0;
        // reset again mid-stream, then pulse with unknown reference (R8, R10)
        @(negedge clk); rst = 1'b1; bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sym(0, 1, 0, 1, 2);
        sym(1, 0, 0, 1, 2);
        sym(0, 0, 0, 0, 3);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule